// File: doc/BRIEF.md
# Paged Non-Volatile Byte Store Controller

This block mediates between a small register interface, of the kind a processor core drives, and a behavioural model of a 256-byte non-volatile array. The array is split into 64 pages of 4 bytes. Software selects a byte with an address register that steps forward on every data access. It fills a 4-entry page latch through a data register and then starts an operation through a control register. The operation can be a write, an erase, or an erase followed by a write. It acts on one byte or on a whole page.

A write can only raise bits: the latched byte is ORed into the stored one. An erase drives every bit of the target to 0. The erase-then-write sequence therefore gives the behaviour of an ordinary store. Each phase is timed by an 8-bit down-counter. The counter is loaded from a reload register and clocked through a fixed prescaler. The controller reports `busy` while a phase runs and pulses `opDone` when the last phase ends. A timer-only operation lets the same counter serve as a plain interval timer.

Top module: `nvm_page_ctrl`

## Requirements
- R1: After reset the address register, reload register and status read 0, `busy` and `opDone` are low, and every array byte reads 0.
- R2: Register select 0 is the address register, which reads back what was written. A read of select 1 returns the array byte at the current address and adds 1 to the address, wrapping from 255 to 0.
- R3: A write to select 1 stores the byte into page-latch entry address[1:0], records the current address as the target, and adds 1 to the address.
- R4: A write to select 2 starts an operation. Bits 1:0 give the kind (00 timer only, 01 write, 10 erase, 11 erase-then-write) and bit 2 set means page mode. A byte write ORs latch entry target[1:0] into the target byte, so bits already at 1 stay 1.
- R5: A byte erase sets only the target byte to 0.
- R6: An erase-then-write leaves exactly the latched value in each affected byte.
- R7: A page operation acts on all 4 bytes of page target[7:2] at once, using latch entries 0 to 3 for bytes 0 to 3. Bytes outside that page are unchanged.
- R8: Each phase lasts reload × PRESCALE clock cycles, and a reload of 0 counts as 256. Erase-then-write runs two phases back to back. `busy` rises on the clock edge that accepts the command and stays high until the last phase ends.
- R9: `opDone` is high for exactly one cycle, in the cycle after the last phase ends, which is also the first cycle with `busy` low.
- R10: While `busy` is high, writes to every register are ignored, including a control write taken on the very edge a phase ends. Reads of select 1 return the array contents from before the operation.
- R11: A timer-only operation runs one phase and changes no array byte. Reading select 2 returns `busy` in bit 0 and 0 in the other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register select: 0 address, 1 data, 2 control/status, 3 reload |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (advances the address on select 1) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| busy | output | 1 | An operation phase is running |
| opDone | output | 1 | One-cycle pulse at the end of an operation |

## Verification
The case where two functions meet in one cycle is a new control write whose capturing edge is the same edge on which the running phase expires. In that cycle the block both finishes one operation and is handed the next. The bench starts a one-tick timer operation and drives the control write so that it is sampled on exactly that edge. On the following cycle it expects `opDone` high and `busy` low. One cycle later it expects `busy` still low, which shows the command was dropped rather than queued. A second timing overlap is covered by a data read taken while an erase runs: it must return the old byte.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR   = 2'd0,
    SEL_DATA   = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_RELOAD = 2'd3
  } regSel_t;

  typedef enum logic [1:0] {
    OP_TIMER = 2'd0,
    OP_WRITE = 2'd1,
    OP_ERASE = 2'd2,
    OP_ERWR  = 2'd3
  } opKind_t;

  // strobes from the sequencer to the datapath and timer
  typedef struct packed {
    logic loadTimer;
    logic eraseNow;
    logic writeNow;
    logic pageMode;
  } ctlStrobe_t;

endpackage

// File: rtl/nvm_phase_timer.sv
module nvm_phase_timer #(
  parameter int PRESCALE = 16,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] reloadVal,
  output logic             expire
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] downCnt;
  logic             tick;

  assign tick   = (preCnt == PRE_LAST);
  // phase ends on the tick that would take the counter from 1 to 0
  assign expire = run && tick && (downCnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      downCnt <= '0;
    end else if (load) begin
      preCnt  <= '0;
      downCnt <= reloadVal;
    end else if (run) begin
      if (tick) begin
        preCnt  <= '0;
        downCnt <= downCnt - CNT_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

endmodule

// File: rtl/nvm_ctrl_fsm.sv
module nvm_ctrl_fsm
  import nvm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdGo,
  input  opKind_t    cmdOp,
  input  logic       cmdPage,
  input  logic       phaseExpire,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       opDone
);
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_WRITE = 2'd2,
    ST_TIMER = 2'd3
  } state_t;

  state_t  stateQ, stateNext;
  opKind_t opQ;
  logic    pageQ;
  logic    finish;

  always_comb begin
    stateNext       = stateQ;
    strobe          = '0;
    strobe.pageMode = pageQ;
    finish          = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (cmdGo) begin
          strobe.loadTimer = 1'b1;
          unique case (cmdOp)
            OP_TIMER: stateNext = ST_TIMER;
            OP_WRITE: stateNext = ST_WRITE;
            default:  stateNext = ST_ERASE;
          endcase
        end
      end
      ST_ERASE: begin
        if (phaseExpire) begin
          strobe.eraseNow = 1'b1;
          if (opQ == OP_ERWR) begin
            stateNext        = ST_WRITE;
            strobe.loadTimer = 1'b1;
          end else begin
            stateNext = ST_IDLE;
            finish    = 1'b1;
          end
        end
      end
      ST_WRITE: begin
        if (phaseExpire) begin
          strobe.writeNow = 1'b1;
          stateNext       = ST_IDLE;
          finish          = 1'b1;
        end
      end
      default: begin
        if (phaseExpire) begin
          stateNext = ST_IDLE;
          finish    = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      opQ    <= OP_TIMER;
      pageQ  <= 1'b0;
      opDone <= 1'b0;
    end else begin
      stateQ <= stateNext;
      opDone <= finish;
      if (stateQ == ST_IDLE && cmdGo) begin
        opQ   <= cmdOp;
        pageQ <= cmdPage;
      end
    end
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/nvm_datapath.sv
module nvm_datapath
  import nvm_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  regSel_t           regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  input  ctlStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] reloadQ,
  output logic [ADDR_W-1:0] addrQ
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BSEL_W = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - BSEL_W;

  logic [DATA_W-1:0] mem      [DEPTH];
  logic [DATA_W-1:0] pageLatch[PAGE_BYTES];
  logic [ADDR_W-1:0] tgtQ;
  logic              accept;
  logic [PAGE_W-1:0] tgtPage;

  assign accept  = wrEn && !busy;
  assign tgtPage = tgtQ[ADDR_W-1:BSEL_W];

  // register file: address, target, latch, reload
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      tgtQ    <= '0;
      reloadQ <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageLatch[i] <= '0;
    end else begin
      if (accept && regSel == SEL_ADDR) begin
        addrQ <= ADDR_W'(wrData);
      end else if (regSel == SEL_DATA && (rdEn || accept)) begin
        addrQ <= addrQ + ADDR_W'(1);
      end
      if (accept && regSel == SEL_DATA) begin
        pageLatch[addrQ[BSEL_W-1:0]] <= wrData;
        tgtQ <= addrQ;
      end
      if (accept && regSel == SEL_RELOAD) reloadQ <= wrData;
    end
  end

  // behavioural array: one slice per byte lane of a page
  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_lane
    logic laneHit;
    assign laneHit = strobe.pageMode || (tgtQ[BSEL_W-1:0] == BSEL_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int p = 0; p < (DEPTH / PAGE_BYTES); p++) mem[p*PAGE_BYTES + b] <= '0;
      end else if (laneHit) begin
        if (strobe.eraseNow)
          mem[{tgtPage, BSEL_W'(b)}] <= '0;
        else if (strobe.writeNow)
          mem[{tgtPage, BSEL_W'(b)}] <= mem[{tgtPage, BSEL_W'(b)}] | pageLatch[b];
      end
    end
  end

  always_comb begin
    unique case (regSel)
      SEL_ADDR: rdData = DATA_W'(addrQ);
      SEL_DATA: rdData = mem[addrQ];
      SEL_CTRL: rdData = DATA_W'(busy);
      default:  rdData = reloadQ;
    endcase
  end

endmodule

// File: rtl/nvm_page_ctrl.sv
module nvm_page_ctrl
  import nvm_pkg::*;
#(
  parameter int PRESCALE   = 16,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              opDone
);
  ctlStrobe_t        strobe;
  logic              phaseExpire;
  logic              cmdGo;
  logic [DATA_W-1:0] reloadQ;
  logic [ADDR_W-1:0] addrQ;
  regSel_t           selT;

  assign selT  = regSel_t'(regSel);
  assign cmdGo = wrEn && (selT == SEL_CTRL) && !busy;

  nvm_ctrl_fsm u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdGo      (cmdGo),
    .cmdOp      (opKind_t'(wrData[1:0])),
    .cmdPage    (wrData[2]),
    .phaseExpire(phaseExpire),
    .strobe     (strobe),
    .busy       (busy),
    .opDone     (opDone)
  );

  nvm_phase_timer #(.PRESCALE(PRESCALE), .CNT_W(DATA_W)) u_timer (
    .clk      (clk),
    .rstN     (rstN),
    .load     (strobe.loadTimer),
    .run      (busy),
    .reloadVal(reloadQ),
    .expire   (phaseExpire)
  );

  nvm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .regSel (selT),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .wrData (wrData),
    .busy   (busy),
    .strobe (strobe),
    .rdData (rdData),
    .reloadQ(reloadQ),
    .addrQ  (addrQ)
  );

endmodule

// File: rtl/nvm_page_ctrl_chk.sv
module nvm_page_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        regSel,
  input logic              wrEn,
  input logic              rdEn,
  input logic              busy,
  input logic              opDone,
  input logic [ADDR_W-1:0] addrQ
);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> !opDone);

  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> (!busy && $past(busy)));

  assert_busy_fall_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> opDone);

  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == 2'd2 && !busy) |=> busy);

  assert_read_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel == 2'd1) |=> (addrQ == $past(addrQ) + ADDR_W'(1)));

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && !rdEn) |=> (addrQ == $past(addrQ)));

endmodule

bind nvm_page_ctrl nvm_page_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .regSel(regSel),
  .wrEn  (wrEn),
  .rdEn  (rdEn),
  .busy  (busy),
  .opDone(opDone),
  .addrQ (addrQ)
);

// File: tb/nvm_page_ctrl_test.sv
module nvm_page_ctrl_test;
  localparam int PRE = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       busy;
  logic       opDone;

  int checks = 0;
  int fails = 0;
  bit ended = 0;

  nvm_page_ctrl #(.PRESCALE(PRE)) uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .busy(busy), .opDone(opDone)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [7:0] v);
    @(negedge clk);
    regSel = sel; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic readByte(input logic [7:0] a, output logic [7:0] v);
    regWrite(2'd0, a);
    regRead(2'd1, v);
  endtask

  // call right after the control write; counts busy cycles, checks the end
  task automatic waitDone(input string tag, input int expCycles);
    int n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
    if (expCycles >= 0) check({tag, " busy cycles"}, n, expCycles);
    check({tag, " done pulse"}, opDone, 1);
    @(negedge clk);
    check({tag, " done single"}, opDone, 0);
  endtask

  task automatic tReset();
    logic [7:0] v;
    check("R1 busy", busy, 0);
    check("R1 opDone", opDone, 0);
    regRead(2'd0, v); check("R1 addr", v, 0);
    regRead(2'd3, v); check("R1 reload", v, 0);
    regRead(2'd2, v); check("R1 status", v, 0);
    readByte(8'h9C, v); check("R1 array", v, 0);
  endtask

  task automatic tAddrWrap();
    logic [7:0] v;
    regWrite(2'd0, 8'hFF);
    regRead(2'd0, v); check("R2 addr readback", v, 8'hFF);
    regRead(2'd1, v); check("R2 data read", v, 0);
    regRead(2'd0, v); check("R2 wrap", v, 0);
  endtask

  task automatic tByteWrite();
    logic [7:0] v;
    regWrite(2'd3, 8'd2);
    regWrite(2'd0, 8'h10);
    regWrite(2'd1, 8'h5A);
    regRead(2'd0, v); check("R3 addr step", v, 8'h11);
    regWrite(2'd2, 8'b001);
    waitDone("R4 write", 2 * PRE);
    readByte(8'h10, v); check("R4 first write", v, 8'h5A);
    regWrite(2'd0, 8'h10);
    regWrite(2'd1, 8'h81);
    regWrite(2'd2, 8'b001);
    waitDone("R4 or", -1);
    readByte(8'h10, v); check("R4 or-merge", v, 8'hDB);
    regWrite(2'd0, 8'h11);
    regWrite(2'd1, 8'h3C);
    regWrite(2'd2, 8'b001);
    waitDone("R4 neighbour", -1);
    readByte(8'h11, v); check("R4 lane1", v, 8'h3C);
  endtask

  task automatic tEraseWrite();
    logic [7:0] v;
    regWrite(2'd0, 8'h10);
    regWrite(2'd1, 8'h24);
    regWrite(2'd2, 8'b011);
    waitDone("R8 erase-write", 4 * PRE);
    readByte(8'h10, v); check("R6 byte erase-write", v, 8'h24);
  endtask

  task automatic tByteErase();
    logic [7:0] v;
    regWrite(2'd0, 8'h11);
    regWrite(2'd1, 8'h00);
    regWrite(2'd0, 8'h11);
    regWrite(2'd2, 8'b010);
    regRead(2'd1, v); check("R10 read during erase", v, 8'h3C);
    regRead(2'd2, v); check("R11 status busy", v, 1);
    waitDone("R5 erase", -1);
    readByte(8'h11, v); check("R5 erased", v, 0);
    readByte(8'h10, v); check("R5 neighbour kept", v, 8'h24);
  endtask

  task automatic tPage();
    logic [7:0] v;
    regWrite(2'd0, 8'h20);
    regWrite(2'd1, 8'h11); regWrite(2'd1, 8'h22);
    regWrite(2'd1, 8'h33); regWrite(2'd1, 8'h44);
    regWrite(2'd2, 8'b101);
    waitDone("R7 page write", 2 * PRE);
    readByte(8'h20, v); check("R7 b0", v, 8'h11);
    readByte(8'h21, v); check("R7 b1", v, 8'h22);
    readByte(8'h23, v); check("R7 b3", v, 8'h44);
    readByte(8'h24, v); check("R7 above page", v, 0);
    readByte(8'h1F, v); check("R7 below page", v, 0);
    regWrite(2'd0, 8'h20);
    regWrite(2'd1, 8'hF0); regWrite(2'd1, 8'h0F);
    regWrite(2'd1, 8'hA5); regWrite(2'd1, 8'h00);
    regWrite(2'd2, 8'b111);
    waitDone("R7 page erase-write", 4 * PRE);
    readByte(8'h20, v); check("R6 page b0", v, 8'hF0);
    readByte(8'h22, v); check("R6 page b2", v, 8'hA5);
    readByte(8'h23, v); check("R6 page b3", v, 8'h00);
    regWrite(2'd2, 8'b110);
    waitDone("R7 page erase", 2 * PRE);
    readByte(8'h21, v); check("R7 page erased", v, 0);
    readByte(8'h10, v); check("R7 other page", v, 8'h24);
  endtask

  task automatic tTimer();
    logic [7:0] v;
    regWrite(2'd3, 8'd3);
    regWrite(2'd2, 8'b000);
    waitDone("R8 timer 3", 3 * PRE);
    readByte(8'h10, v); check("R11 array untouched", v, 8'h24);
    regWrite(2'd3, 8'd0);
    regWrite(2'd2, 8'b100);
    waitDone("R8 reload zero", 256 * PRE);
  endtask

  task automatic tIgnore();
    logic [7:0] v;
    regWrite(2'd3, 8'd5);
    regWrite(2'd0, 8'h40);
    regWrite(2'd2, 8'b000);
    regWrite(2'd0, 8'h77);
    regWrite(2'd3, 8'd9);
    regWrite(2'd2, 8'b001);
    waitDone("R10 busy", -1);
    check("R10 no restart", busy, 0);
    regRead(2'd0, v); check("R10 addr kept", v, 8'h40);
    regRead(2'd3, v); check("R10 reload kept", v, 5);
  endtask

  task automatic tCoincident();
    regWrite(2'd3, 8'd1);
    regWrite(2'd2, 8'b000);
    repeat (PRE - 1) @(negedge clk);
    regSel = 2'd2; wrData = 8'b001; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check("R9 done on expiry", opDone, 1);
    check("R9 busy low", busy, 0);
    @(negedge clk);
    check("R10 command at expiry dropped", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tAddrWrap();
    tByteWrite();
    tEraseWrite();
    tByteErase();
    tPage();
    tTimer();
    tIgnore();
    tCoincident();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++;
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule